// File: doc/BRIEF.md
# Denied Access Counter and First-Denial Log

This block sits behind an address range filter and watches the denial events it produces. Every denial adds one to a counter. The counter stops climbing at a programmable threshold. While the count is at or above that threshold, a level interrupt is raised toward the security controller. Acknowledging the interrupt clears the counter.

Alongside the counter, a one-shot log keeps a snapshot of the first denial seen since reset or since the last clear. The snapshot holds the range index, a flag for "no range matched", the access type, the requester's role, the role-check cause and the address. Later denials do not touch the snapshot. It is emptied either by the interrupt acknowledge or by a separate manual clear. A denial that arrives in the same cycle as a clear is applied after the clear, so it is counted and logged.

All state is registered and uses a synchronous active-low reset. Each output reflects an event on the clock edge that samples it.

Top module: `deny_monitor`

## Requirements
- R1: Each cycle with `deny_valid_i` high raises `count_o` by exactly one on the next edge, whatever the access type, as long as the count is below the threshold and no acknowledge is present.
- R2: When `count_o` is at or above `threshold_i`, a denial leaves `count_o` unchanged.
- R3: `irq_o` is high exactly when `threshold_i` is non-zero and `count_o >= threshold_i`. It is a level and falls without an acknowledge if the threshold is raised above the count.
- R4: `irq_ack_i` sets `count_o` to zero on the next edge. If a denial arrives in the same cycle and the threshold is non-zero, the count becomes one.
- R5: A denial seen while the log is empty sets `log_valid_o`. On the next edge it records the range index, access type (2 bits: 0 read, 1 write, 2 execute), role, cause (bit 0: role read check failed, bit 1: role write check failed) and address.
- R6: While `log_valid_o` is high and no clear is present, later denials leave every log output unchanged.
- R7: A logged denial with `deny_nomatch_i` high sets `log_nomatch_o`, and `log_range_o` then reads zero.
- R8: `irq_ack_i` or `log_clear_i` empties the log on the next edge. A denial in the same cycle is captured instead, leaving the log valid with the new fields.
- R9: After reset, the count, the interrupt and all log outputs are zero.
- R10: With `threshold_i` equal to zero, denials do not change the count and `irq_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| deny_valid_i | input | 1 | One denial event this cycle |
| deny_range_i | input | IdxW | Index of the range that denied the access |
| deny_nomatch_i | input | 1 | Denial because no range matched |
| deny_access_i | input | 2 | Access type: 0 read, 1 write, 2 execute |
| deny_role_i | input | RoleW | Role of the requester |
| deny_cause_i | input | 2 | Role-check cause: bit 0 read check, bit 1 write check |
| deny_addr_i | input | AddrW | Address of the denied access |
| threshold_i | input | CntW | Saturation and interrupt threshold |
| irq_ack_i | input | 1 | Interrupt acknowledge, clears count and log |
| log_clear_i | input | 1 | Manual log clear |
| count_o | output | CntW | Denied access count |
| irq_o | output | 1 | Level interrupt |
| log_valid_o | output | 1 | Log holds a denial |
| log_range_o | output | IdxW | Logged range index |
| log_nomatch_o | output | 1 | Logged no-match flag |
| log_access_o | output | 2 | Logged access type |
| log_role_o | output | RoleW | Logged role |
| log_cause_o | output | 2 | Logged role-check cause |
| log_addr_o | output | AddrW | Logged address |

## Verification
The count and the log are plain registers that appear at the ports, so a wrong internal state shows up on the edge right after the event that caused it. A count that skips or repeats a value differs from the model in that cycle. A count that passes the threshold raises the interrupt too early or holds it too long. A log overwritten by a later denial shows changed fields on the very next edge. The bench compares every output against a behavioural model on every clock, so any divergence is reported in the cycle it first appears.

// File: rtl/deny_monitor_pkg.sv
// Package: shared types for the denied access counter and log.
// Assumes: the access type is a 2-bit code, and the role-check cause is a
// 2-bit vector with one bit for the read check and one for the write check.
package deny_monitor_pkg;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2
    } dm_access_e;

    localparam int unsigned CauseW = 2;

endpackage

// File: rtl/deny_counter.sv
// Module: deny_counter
// Counts denial pulses and saturates at a threshold supplied at run time.
// Raises a level interrupt while the count is at or above a non-zero threshold.
// Assumes: inc_i is at most one event per cycle, and an acknowledge takes
// effect before a same-cycle increment.
module deny_counter #(
    parameter int unsigned CntW = 16
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            inc_i,
    input  logic            ack_i,
    input  logic [CntW-1:0] thr_i,
    output logic [CntW-1:0] count_o,
    output logic            irq_o
);

    localparam logic [CntW-1:0] One = CntW'(1);

    logic [CntW-1:0] count_q;
    logic [CntW-1:0] base;
    logic [CntW-1:0] count_d;
    logic            below;

    // Value the count starts from this cycle, once any acknowledge is applied.
    always_comb base = ack_i ? '0 : count_q;

    // Increment only while the count is still under the threshold.
    always_comb below = (base < thr_i);

    // Next count, with saturation at the threshold.
    always_comb count_d = (inc_i && below) ? (base + One) : base;

    // Count register.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) count_q <= '0;
        else         count_q <= count_d;
    end

    // Level interrupt derived from the stored count and the current threshold.
    always_comb irq_o = (thr_i != '0) && (count_q >= thr_i);

    assign count_o = count_q;

    // R1: a denial under the threshold adds exactly one.
    assert_count_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!ack_i && inc_i && (count_q < thr_i)) |=> (count_q == $past(count_q) + One));

    // R2: no growth at or above the threshold.
    assert_saturate_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!ack_i && (count_q >= thr_i)) |=> (count_q == $past(count_q)));

    // R4: an acknowledge restarts the count from zero.
    assert_ack_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ack_i && !inc_i) |=> (count_q == '0));

    // R4: a same-cycle denial after the acknowledge is counted.
    assert_ack_and_deny_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ack_i && inc_i && (thr_i != '0)) |=> (count_q == One));

    // R10: a zero threshold never raises the interrupt.
    assert_zero_thr_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (thr_i == '0) |-> !irq_o);

endmodule

// File: rtl/deny_log.sv
// Module: deny_log
// One-shot capture of the first denial after reset or after a clear.
// Assumes: a clear this cycle empties the log before a same-cycle event
// is considered, so that event is captured. The range field is stored as
// zero for no-match denials.
module deny_log
    import deny_monitor_pkg::*;
#(
    parameter int unsigned IdxW  = 5,
    parameter int unsigned RoleW = 4,
    parameter int unsigned AddrW = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              ev_i,
    input  logic              clear_i,
    input  logic [IdxW-1:0]   range_i,
    input  logic              nomatch_i,
    input  logic [1:0]        access_i,
    input  logic [RoleW-1:0]  role_i,
    input  logic [CauseW-1:0] cause_i,
    input  logic [AddrW-1:0]  addr_i,
    output logic              valid_o,
    output logic [IdxW-1:0]   range_o,
    output logic              nomatch_o,
    output logic [1:0]        access_o,
    output logic [RoleW-1:0]  role_o,
    output logic [CauseW-1:0] cause_o,
    output logic [AddrW-1:0]  addr_o
);

    logic              valid_q;
    logic [IdxW-1:0]   range_q;
    logic              nomatch_q;
    dm_access_e        access_q;
    logic [RoleW-1:0]  role_q;
    logic [CauseW-1:0] cause_q;
    logic [AddrW-1:0]  addr_q;
    logic              empty;
    logic              capture;

    // The log counts as empty when it holds nothing or is being cleared.
    always_comb empty = clear_i || !valid_q;

    // Take a snapshot when an event meets an empty log.
    always_comb capture = ev_i && empty;

    // Valid flag register.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)      valid_q <= 1'b0;
        else if (capture) valid_q <= 1'b1;
        else if (clear_i) valid_q <= 1'b0;
    end

    // Field registers: load on capture, zero on a clear without an event.
    always_ff @(posedge clk_i) begin
        if (!rst_ni || (clear_i && !capture)) begin
            range_q   <= '0;
            nomatch_q <= 1'b0;
            access_q  <= ACC_READ;
            role_q    <= '0;
            cause_q   <= '0;
            addr_q    <= '0;
        end else if (capture) begin
            range_q   <= nomatch_i ? '0 : range_i;
            nomatch_q <= nomatch_i;
            access_q  <= dm_access_e'(access_i);
            role_q    <= role_i;
            cause_q   <= cause_i;
            addr_q    <= addr_i;
        end
    end

    assign valid_o   = valid_q;
    assign range_o   = range_q;
    assign nomatch_o = nomatch_q;
    assign access_o  = access_q;
    assign role_o    = role_q;
    assign cause_o   = cause_q;
    assign addr_o    = addr_q;

    // R5: an event meeting an empty log is recorded.
    assert_capture_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ev_i && !valid_q) |=> (valid_q && (addr_q == $past(addr_i)) && (role_q == $past(role_i))));

    // R6: a held log is not overwritten.
    assert_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_q && !clear_i) |=> (valid_q && $stable(addr_q) && $stable(range_q)
                                   && $stable(access_q) && $stable(cause_q)));

    // R7: a no-match capture reports range zero.
    assert_nomatch_range_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        nomatch_q |-> (range_q == '0));

    // R8: a clear with no event empties the log.
    assert_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clear_i && !ev_i) |=> !valid_q);

    // R8: a clear with an event keeps the new event.
    assert_clear_capture_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clear_i && ev_i) |=> (valid_q && (addr_q == $past(addr_i))));

endmodule

// File: rtl/deny_monitor.sv
// Module: deny_monitor (top)
// Combines the saturating denial counter and the first-denial log.
// The interrupt acknowledge clears both. The manual clear empties only the log.
// Assumes: at most one denial event per cycle from the range filter.
module deny_monitor
    import deny_monitor_pkg::*;
#(
    parameter int unsigned NumRanges = 32,
    parameter int unsigned RoleW     = 4,
    parameter int unsigned AddrW     = 32,
    parameter int unsigned CntW      = 16,
    localparam int unsigned IdxW     = (NumRanges > 1) ? $clog2(NumRanges) : 1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             deny_valid_i,
    input  logic [IdxW-1:0]  deny_range_i,
    input  logic             deny_nomatch_i,
    input  logic [1:0]       deny_access_i,
    input  logic [RoleW-1:0] deny_role_i,
    input  logic [1:0]       deny_cause_i,
    input  logic [AddrW-1:0] deny_addr_i,
    input  logic [CntW-1:0]  threshold_i,
    input  logic             irq_ack_i,
    input  logic             log_clear_i,
    output logic [CntW-1:0]  count_o,
    output logic             irq_o,
    output logic             log_valid_o,
    output logic [IdxW-1:0]  log_range_o,
    output logic             log_nomatch_o,
    output logic [1:0]       log_access_o,
    output logic [RoleW-1:0] log_role_o,
    output logic [1:0]       log_cause_o,
    output logic [AddrW-1:0] log_addr_o
);

    logic log_wipe;

    // Either clear source empties the log.
    always_comb log_wipe = irq_ack_i || log_clear_i;

    deny_counter #(
        .CntW (CntW)
    ) u_counter (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .inc_i   (deny_valid_i),
        .ack_i   (irq_ack_i),
        .thr_i   (threshold_i),
        .count_o (count_o),
        .irq_o   (irq_o)
    );

    deny_log #(
        .IdxW  (IdxW),
        .RoleW (RoleW),
        .AddrW (AddrW)
    ) u_log (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .ev_i      (deny_valid_i),
        .clear_i   (log_wipe),
        .range_i   (deny_range_i),
        .nomatch_i (deny_nomatch_i),
        .access_i  (deny_access_i),
        .role_i    (deny_role_i),
        .cause_i   (deny_cause_i[CauseW-1:0]),
        .addr_i    (deny_addr_i),
        .valid_o   (log_valid_o),
        .range_o   (log_range_o),
        .nomatch_o (log_nomatch_o),
        .access_o  (log_access_o),
        .role_o    (log_role_o),
        .cause_o   (log_cause_o),
        .addr_o    (log_addr_o)
    );

    // R9: outputs are quiet in the cycle after reset.
    assert_reset_quiet_R9: assert property (@(posedge clk_i)
        !rst_ni |=> ((count_o == '0) && !log_valid_o));

endmodule

// File: tb/deny_monitor_bench.sv
`timescale 1ns/1ps
module deny_monitor_bench;

    localparam int NR = 32, RW = 4, AW = 32, CW = 16, IW = 5;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst_n;
    logic          dv;
    logic [IW-1:0] drange;
    logic          dnm;
    logic [1:0]    dacc;
    logic [RW-1:0] drole;
    logic [1:0]    dcause;
    logic [AW-1:0] daddr;
    logic [CW-1:0] thr;
    logic          ack;
    logic          clr;

    logic [CW-1:0] count;
    logic          irq;
    logic          lv;
    logic [IW-1:0] lrange;
    logic          lnm;
    logic [1:0]    lacc;
    logic [RW-1:0] lrole;
    logic [1:0]    lcause;
    logic [AW-1:0] laddr;

    deny_monitor #(.NumRanges(NR), .RoleW(RW), .AddrW(AW), .CntW(CW)) u_deny_monitor (
        .clk_i(clk), .rst_ni(rst_n), .deny_valid_i(dv), .deny_range_i(drange),
        .deny_nomatch_i(dnm), .deny_access_i(dacc), .deny_role_i(drole),
        .deny_cause_i(dcause), .deny_addr_i(daddr), .threshold_i(thr),
        .irq_ack_i(ack), .log_clear_i(clr), .count_o(count), .irq_o(irq),
        .log_valid_o(lv), .log_range_o(lrange), .log_nomatch_o(lnm),
        .log_access_o(lacc), .log_role_o(lrole), .log_cause_o(lcause),
        .log_addr_o(laddr)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Behavioural model state.
    int          m_cnt;
    bit          m_lv;
    int          m_range, m_acc, m_role, m_cause;
    bit          m_nm;
    longint      m_addr;

    task automatic chk(string req, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Compare every output against the model.
    task automatic compare(string req);
        chk(req, "count", longint'(count), longint'(m_cnt));
        chk(req, "irq", longint'(irq), longint'((thr != 0) && (m_cnt >= int'(thr))));
        chk(req, "log_valid", longint'(lv), longint'(m_lv));
        chk(req, "log_range", longint'(lrange), longint'(m_range));
        chk(req, "log_nomatch", longint'(lnm), longint'(m_nm));
        chk(req, "log_access", longint'(lacc), longint'(m_acc));
        chk(req, "log_role", longint'(lrole), longint'(m_role));
        chk(req, "log_cause", longint'(lcause), longint'(m_cause));
        chk(req, "log_addr", longint'(laddr), m_addr);
    endtask

    // Advance one clock: update the model from current inputs, then compare.
    task automatic tick(string req);
        int c;
        c = ack ? 0 : m_cnt;
        if (dv && c < int'(thr)) c++;
        m_cnt = c;
        if (ack || clr) begin
            m_lv = 0; m_range = 0; m_nm = 0; m_acc = 0; m_role = 0; m_cause = 0; m_addr = 0;
        end
        if (dv && !m_lv) begin
            m_lv = 1; m_nm = dnm; m_range = dnm ? 0 : int'(drange);
            m_acc = int'(dacc); m_role = int'(drole); m_cause = int'(dcause);
            m_addr = longint'(daddr);
        end
        @(posedge clk);
        #1;
        compare(req);
    endtask

    task automatic deny(int r, bit nm, int a, int role, int cause, longint addr);
        dv = 1; drange = IW'(r); dnm = nm; dacc = 2'(a); drole = RW'(role);
        dcause = 2'(cause); daddr = AW'(addr);
    endtask

    task automatic idle();
        dv = 0; ack = 0; clr = 0;
    endtask

    initial begin
        int wd = 0;
        while (!done && wd < 100000) begin
            @(posedge clk);
            wd++;
        end
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", wd, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 0; idle(); thr = 16'd3;
        drange = '0; dnm = 0; dacc = 0; drole = 0; dcause = 0; daddr = 0;
        m_cnt = 0; m_lv = 0; m_range = 0; m_nm = 0; m_acc = 0; m_role = 0; m_cause = 0; m_addr = 0;
        // Hold reset while denials are offered: nothing may be recorded.
        repeat (3) @(posedge clk);
        deny(4, 0, 1, 2, 1, 32'h1000);
        @(posedge clk); #1;
        compare("R9 reset");
        idle();
        rst_n = 1;
        tick("R9 after reset");

        // R5 first denial captured; R1 counted.
        deny(7, 0, 1, 5, 2, 32'hDEAD_0040);
        tick("R5 first capture / R1 count");
        // R6 later denials of other types leave log; R1 still counts.
        deny(9, 0, 0, 3, 1, 32'h0000_1234);
        tick("R6 hold / R1 read counted");
        deny(2, 1, 2, 1, 0, 32'hFFFF_FFFC);
        tick("R6 hold / R1 exec counted, R3 irq");
        // R2 saturation at threshold 3.
        deny(11, 0, 1, 0, 3, 32'h8);
        tick("R2 saturate");
        tick("R2 saturate again");
        idle();
        // R3 level: raise threshold above count, irq falls.
        thr = 16'd5;
        tick("R3 threshold raised");
        deny(1, 0, 0, 0, 0, 32'h10);
        tick("R1 count under new threshold");
        deny(1, 0, 0, 0, 0, 32'h14);
        tick("R3 irq at new threshold");
        idle();
        tick("R3 irq level held");
        // R4 acknowledge clears count and log (R8).
        ack = 1;
        tick("R4 ack clear / R8 log cleared");
        idle();
        tick("R8 log empty");
        // R7 no-match denial logged with range zero.
        deny(13, 1, 1, 6, 2, 32'h4000_0000);
        tick("R7 no-match capture");
        // R8 manual clear with same-cycle denial recaptures; counter untouched by clear.
        clr = 1;
        deny(21, 0, 2, 9, 1, 32'h0ABC_DEF0);
        tick("R8 clear plus deny captured");
        idle();
        clr = 1;
        tick("R8 manual clear");
        idle();
        // R4 ack and deny in the same cycle.
        deny(3, 0, 0, 1, 1, 32'h20);
        tick("R1 build count");
        ack = 1;
        deny(30, 0, 1, 15, 3, 32'h7777_0000);
        tick("R4 ack plus deny counts one");
        idle();
        // R10 zero threshold.
        thr = 16'd0;
        tick("R10 zero threshold irq low");
        ack = 1;
        tick("R10 clear before zero-threshold test");
        idle();
        deny(5, 0, 1, 2, 2, 32'h30);
        tick("R10 deny with zero threshold");
        tick("R10 deny again");
        idle();
        // Mixed random traffic against the model.
        thr = 16'd6;
        for (int i = 0; i < 400; i++) begin
            dv  = ($urandom % 3) != 0;
            drange = IW'($urandom); dnm = ($urandom % 5) == 0;
            dacc = 2'($urandom % 3); drole = RW'($urandom); dcause = 2'($urandom);
            daddr = AW'($urandom);
            ack = ($urandom % 17) == 0;
            clr = ($urandom % 13) == 0;
            if (($urandom % 50) == 0) thr = CW'($urandom % 8);
            tick("R1 R2 R3 R4 R5 R6 R7 R8 mixed");
        end
        idle();
        tick("final idle");
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule